// File: doc/BRIEF.md
# Four-Channel DMA Programming and Enable Controller

This block holds the software-visible programming state of a four-channel, byte-wide DMA controller. A small I/O write port loads each channel's 16-bit start address and 16-bit transfer length one byte at a time. A single byte-pointer flip-flop, shared by all channels, selects which byte each write replaces. The same port also writes a per-channel mask, a per-channel mode and a command register, and it can force the byte pointer back to the low byte. A separate port writes an 8-bit page value for each channel.

For every channel the block keeps a current address and a current count. Together with the page, these form a 24-bit physical address. A per-channel load input starts a transfer by copying the programmed values into the current registers. A per-channel step input advances the transfer by one byte. Each channel drives an enable output that says whether it may service requests. This enable is recomputed whenever the count, the mask or the mode is written. A channel in single-cycle mode also drops its enable by itself when its count runs out. A channel in autoinit mode instead reloads its current registers and stays enabled. A one-cycle toggle pulse marks every change of an enable.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel is masked, its enable is 0, its current count is 0, its toggle pulse and the command error are 0, and the byte pointer selects the low byte.
- R2: Writes to offsets 0x00/0x02/0x04/0x06 (address, channels 0..3) and 0x01/0x03/0x05/0x07 (count, channels 0..3) replace the low byte when the shared pointer is set and the high byte when it is clear. Every such write toggles the pointer, and the pointer is shared between channels and between address and count.
- R3: A write of any value to offset 0x0C sets the byte pointer, so the next address or count write lands in the low byte.
- R4: A write to offset 0x0A selects the channel with data bits 1:0. Data bit 2 = 1 masks that channel and bit 2 = 0 unmasks it. A masked channel always has enable 0.
- R5: A write to offset 0x0B selects the channel with data bits 1:0. Data bit 4 = 1 selects autoinit mode and bit 4 = 0 selects single-cycle mode. The other mode bits have no effect.
- R6: A load pulse on a channel sets its current address to the programmed address and its current count to the programmed count plus one, and it clears the channel's reprogrammed flag. The physical address output is always the page byte (written through the page port) above the 16-bit current address.
- R7: When an enable is evaluated, the result is 1 exactly when the channel is unmasked and at least one of these holds: it is in autoinit mode, its current count is nonzero, or its address or count has been written since its last load.
- R8: An enable is evaluated only on a count write, a mask write or a mode write for that channel. Address writes, page writes and loads leave the enable unchanged.
- R9: A step pulse on an enabled channel with a nonzero count increments the 16-bit current address (wrapping from 0xFFFF to 0x0000 without touching the page) and decrements the count. A step pulse on a disabled channel or a channel with zero count is ignored.
- R10: In single-cycle mode, the step that brings the count to zero also clears the enable, with no register write.
- R11: In autoinit mode, the step that would bring the count to zero instead reloads the current address and count as a load does, and the enable stays 1.
- R12: A channel's toggle output is 1 for exactly the one cycle in which its enable first shows a new value.
- R13: A write to offset 0x08 with any value other than 0x04 raises the command error for the following cycle only. A write of 0x04 leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | Register write strobe |
| io_ofs | input | 4 | Register offset |
| io_data | input | 8 | Register write data |
| page_we | input | 1 | Page write strobe |
| page_ch | input | 2 | Channel for the page write |
| page_data | input | 8 | Page value |
| xfer_load | input | 4 | Per-channel transfer start (load current registers) |
| xfer_step | input | 4 | Per-channel one-byte transfer step |
| chan_en | output | 4 | Per-channel enable |
| en_toggle | output | 4 | Per-channel one-cycle pulse on enable change |
| cur_addr | output | 64 | Current addresses, channel n at bits 16n+15:16n |
| cur_count | output | 68 | Current counts, channel n at bits 17n+16:17n |
| phys_addr | output | 96 | Physical addresses, channel n at bits 24n+23:24n |
| cmd_err | output | 1 | Illegal command pulse |

## Verification
On every cycle, the assertions check these invariants: a masked channel is never enabled, the toggle pulse matches each enable change, an enable holds still unless an evaluation or an emptying step occurs, and the byte pointer toggles and clears as written. They also check that a step, a load and an autoinit reload each move the current registers as required. Only the bench scenarios can show how programmed values combine with the evaluation rule. These include enables won back through the reprogrammed flag after a count has run out, the low/high landing of bytes in long write sequences, and address wrap without a page carry.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2 * BYTE_W;
  localparam int CNT_W   = ADDR_W + 1;
  localparam int PAGE_W  = BYTE_W;
  localparam int PHYS_W  = PAGE_W + ADDR_W;
  localparam int OFS_W   = 4;

  localparam logic [OFS_W-1:0]  OFS_CMD   = 4'h8;
  localparam logic [OFS_W-1:0]  OFS_MASK  = 4'hA;
  localparam logic [OFS_W-1:0]  OFS_MODE  = 4'hB;
  localparam logic [OFS_W-1:0]  OFS_CLRP  = 4'hC;
  localparam logic [BYTE_W-1:0] CMD_OK    = 8'h04;
  localparam int                MASK_BIT  = 2;
  localparam int                AUTO_BIT  = 4;

  typedef struct packed {
    logic addr_lo;
    logic addr_hi;
    logic cnt_lo;
    logic cnt_hi;
    logic mask_wr;
    logic mask_set;
    logic mode_wr;
    logic mode_auto;
  } chan_ev_t;

  function automatic logic [ADDR_W-1:0] put_byte(input logic [ADDR_W-1:0] word,
                                                 input logic [BYTE_W-1:0] b,
                                                 input logic hi);
    logic [ADDR_W-1:0] r;
    r = word;
    if (hi) r[ADDR_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] start_count(input logic [ADDR_W-1:0] len);
    return {1'b0, len} + CNT_W'(1);
  endfunction

  function automatic logic enable_rule(input logic masked, input logic autoinit,
                                       input logic [CNT_W-1:0] cnt, input logic reprog);
    return !masked && (autoinit || (cnt != '0) || reprog);
  endfunction
endpackage

// File: rtl/dma_port_decode.sv
`timescale 1ns/1ps
module dma_port_decode
  import dma_chan_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         io_we,
  input  logic [OFS_W-1:0]             io_ofs,
  input  logic [BYTE_W-1:0]            io_data,
  output chan_ev_t [NUM_CH-1:0]        ev,
  output logic                         cmd_err
);
  logic              ptr_low_q;
  logic              reg_wr;
  logic              clr_wr;
  logic              bad_cmd;
  logic [NUM_CH-1:0] reg_hit_vec;

  assign reg_wr  = io_we && !io_ofs[OFS_W-1];
  assign clr_wr  = io_we && (io_ofs == OFS_CLRP);
  assign bad_cmd = io_we && (io_ofs == OFS_CMD) && (io_data != CMD_OK);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      reg_hit_vec[c]   = reg_wr && (io_ofs[CH_W:1] == CH_W'(c));
      ev[c].addr_lo    = reg_hit_vec[c] && !io_ofs[0] &&  ptr_low_q;
      ev[c].addr_hi    = reg_hit_vec[c] && !io_ofs[0] && !ptr_low_q;
      ev[c].cnt_lo     = reg_hit_vec[c] &&  io_ofs[0] &&  ptr_low_q;
      ev[c].cnt_hi     = reg_hit_vec[c] &&  io_ofs[0] && !ptr_low_q;
      ev[c].mask_wr    = io_we && (io_ofs == OFS_MASK) && (io_data[CH_W-1:0] == CH_W'(c));
      ev[c].mask_set   = io_data[MASK_BIT];
      ev[c].mode_wr    = io_we && (io_ofs == OFS_MODE) && (io_data[CH_W-1:0] == CH_W'(c));
      ev[c].mode_auto  = io_data[AUTO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_low_q <= 1'b1;
      cmd_err   <= 1'b0;
    end else begin
      cmd_err <= bad_cmd;
      if (clr_wr)      ptr_low_q <= 1'b1;
      else if (reg_wr) ptr_low_q <= !ptr_low_q;
    end
  end

  assert_clear_sets_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ptr_low_q);
  assert_ptr_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (ptr_low_q != $past(ptr_low_q)));
  assert_one_reg_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_hit_vec));
  assert_bad_cmd_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> cmd_err);
  assert_cmd_err_only_after_bad_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_cmd |=> !cmd_err);
endmodule

// File: rtl/dma_chan_unit.sv
`timescale 1ns/1ps
module dma_chan_unit
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chan_ev_t          ev,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_byte,
  input  logic              load,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [PHYS_W-1:0] phys,
  output logic              en,
  output logic              en_chg
);
  logic [ADDR_W-1:0] base_addr_q, base_addr_d;
  logic [ADDR_W-1:0] base_cnt_q,  base_cnt_d;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] cur_addr_q,  cur_addr_d;
  logic [CNT_W-1:0]  cur_cnt_q,   cur_cnt_d;
  logic              mask_q, mask_d;
  logic              auto_q, auto_d;
  logic              reprog_q, reprog_d;
  logic              en_q, en_d;
  logic              chg_q;

  // named internal events
  logic addr_wr, cnt_wr, eval_evt, step_ok, last_step, empty_evt, reload_evt;

  assign addr_wr    = ev.addr_lo | ev.addr_hi;
  assign cnt_wr     = ev.cnt_lo  | ev.cnt_hi;
  assign eval_evt   = cnt_wr | ev.mask_wr | ev.mode_wr;
  assign step_ok    = step && en_q && (cur_cnt_q != '0) && !load;
  assign last_step  = step_ok && (cur_cnt_q == CNT_W'(1));
  assign empty_evt  = last_step && !auto_q;
  assign reload_evt = last_step &&  auto_q;

  assign base_addr_d = addr_wr ? put_byte(base_addr_q, wr_byte, ev.addr_hi) : base_addr_q;
  assign base_cnt_d  = cnt_wr  ? put_byte(base_cnt_q,  wr_byte, ev.cnt_hi)  : base_cnt_q;
  assign mask_d      = ev.mask_wr ? ev.mask_set  : mask_q;
  assign auto_d      = ev.mode_wr ? ev.mode_auto : auto_q;

  always_comb begin
    if (addr_wr || cnt_wr) reprog_d = 1'b1;
    else if (load)         reprog_d = 1'b0;
    else                   reprog_d = reprog_q;
  end

  always_comb begin
    cur_addr_d = cur_addr_q;
    cur_cnt_d  = cur_cnt_q;
    if (load || reload_evt) begin
      cur_addr_d = base_addr_q;
      cur_cnt_d  = start_count(base_cnt_q);
    end else if (step_ok) begin
      cur_addr_d = cur_addr_q + ADDR_W'(1);
      cur_cnt_d  = cur_cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    if (eval_evt)       en_d = enable_rule(mask_d, auto_d, cur_cnt_d, reprog_d);
    else if (empty_evt) en_d = 1'b0;
    else                en_d = en_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      page_q      <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      mask_q      <= 1'b1;
      auto_q      <= 1'b0;
      reprog_q    <= 1'b0;
      en_q        <= 1'b0;
      chg_q       <= 1'b0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      if (page_wr) page_q <= page_byte;
      cur_addr_q  <= cur_addr_d;
      cur_cnt_q   <= cur_cnt_d;
      mask_q      <= mask_d;
      auto_q      <= auto_d;
      reprog_q    <= reprog_d;
      en_q        <= en_d;
      chg_q       <= (en_d != en_q);
    end
  end

  assign cur_addr = cur_addr_q;
  assign cur_cnt  = cur_cnt_q;
  assign phys     = {page_q, cur_addr_q};
  assign en       = en_q;
  assign en_chg   = chg_q;

  assert_masked_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !en_q);
  assert_toggle_matches_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (chg_q == (en_q != $past(en_q))));
  assert_quiet_enable_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_evt && !empty_evt) |=> $stable(en_q));
  assert_single_empty_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_evt && !eval_evt) |=> (!en_q && (cur_cnt_q == '0)));
  assert_auto_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_evt && !eval_evt) |=> (en_q && (cur_cnt_q != '0) && (cur_addr_q == $past(base_addr_q))));
  assert_step_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !last_step) |=> ((cur_cnt_q + CNT_W'(1)) == $past(cur_cnt_q)
                                 && (cur_addr_q == ADDR_W'($past(cur_addr_q) + ADDR_W'(1)))));
  assert_load_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !addr_wr && !cnt_wr) |=> (!reprog_q && (cur_addr_q == $past(base_addr_q))));
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       io_we,
  input  logic [OFS_W-1:0]           io_ofs,
  input  logic [BYTE_W-1:0]          io_data,
  input  logic                       page_we,
  input  logic [CH_W-1:0]            page_ch,
  input  logic [PAGE_W-1:0]          page_data,
  input  logic [NUM_CH-1:0]          xfer_load,
  input  logic [NUM_CH-1:0]          xfer_step,
  output logic [NUM_CH-1:0]          chan_en,
  output logic [NUM_CH-1:0]          en_toggle,
  output logic [NUM_CH*ADDR_W-1:0]   cur_addr,
  output logic [NUM_CH*CNT_W-1:0]    cur_count,
  output logic [NUM_CH*PHYS_W-1:0]   phys_addr,
  output logic                       cmd_err
);
  chan_ev_t [NUM_CH-1:0] ev;

  dma_port_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_we   (io_we),
    .io_ofs  (io_ofs),
    .io_data (io_data),
    .ev      (ev),
    .cmd_err (cmd_err)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic page_hit;
    assign page_hit = page_we && (page_ch == CH_W'(c));

    dma_chan_unit u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev[c]),
      .wr_byte   (io_data),
      .page_wr   (page_hit),
      .page_byte (page_data),
      .load      (xfer_load[c]),
      .step      (xfer_step[c]),
      .cur_addr  (cur_addr[c*ADDR_W +: ADDR_W]),
      .cur_cnt   (cur_count[c*CNT_W +: CNT_W]),
      .phys      (phys_addr[c*PHYS_W +: PHYS_W]),
      .en        (chan_en[c]),
      .en_chg    (en_toggle[c])
    );
  end

  assert_enable_changes_flagged_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((chan_en != $past(chan_en)) == (en_toggle != '0)));
endmodule

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_we;
  logic [3:0]  io_ofs;
  logic [7:0]  io_data;
  logic        page_we;
  logic [1:0]  page_ch;
  logic [7:0]  page_data;
  logic [3:0]  xfer_load;
  logic [3:0]  xfer_step;
  logic [3:0]  chan_en;
  logic [3:0]  en_toggle;
  logic [63:0] cur_addr;
  logic [67:0] cur_count;
  logic [95:0] phys_addr;
  logic        cmd_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_chan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_ofs(io_ofs), .io_data(io_data),
    .page_we(page_we), .page_ch(page_ch), .page_data(page_data),
    .xfer_load(xfer_load), .xfer_step(xfer_step), .chan_en(chan_en),
    .en_toggle(en_toggle), .cur_addr(cur_addr), .cur_count(cur_count),
    .phys_addr(phys_addr), .cmd_err(cmd_err)
  );

  function automatic logic [31:0] addr_of(int ch);  return 32'(cur_addr[ch*16 +: 16]);  endfunction
  function automatic logic [31:0] cnt_of(int ch);   return 32'(cur_count[ch*17 +: 17]); endfunction
  function automatic logic [31:0] phys_of(int ch);  return 32'(phys_addr[ch*24 +: 24]); endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic io_write(input logic [3:0] ofs, input logic [7:0] d);
    @(negedge clk);
    io_we = 1'b1; io_ofs = ofs; io_data = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic page_write(input logic [1:0] ch, input logic [7:0] d);
    @(negedge clk);
    page_we = 1'b1; page_ch = ch; page_data = d;
    @(negedge clk);
    page_we = 1'b0;
  endtask

  task automatic pulse_load(input logic [3:0] m);
    @(negedge clk); xfer_load = m;
    @(negedge clk); xfer_load = '0;
  endtask

  task automatic pulse_step(input logic [3:0] m);
    @(negedge clk); xfer_step = m;
    @(negedge clk); xfer_step = '0;
  endtask

  task automatic t_reset;
    check("R1", "chan_en", 32'(chan_en), 0);
    check("R1", "en_toggle", 32'(en_toggle), 0);
    check("R1", "cmd_err", 32'(cmd_err), 0);
    check("R1", "count ch0", cnt_of(0), 0);
    check("R1", "count ch3", cnt_of(3), 0);
  endtask

  // R2/R6: bytes land low then high from reset pointer; load copies
  task automatic t_program_load;
    io_write(4'h0, 8'h34);
    io_write(4'h0, 8'h12);
    io_write(4'h1, 8'h03);
    io_write(4'h1, 8'h00);
    check("R4", "masked ch0 after count write", 32'(chan_en[0]), 0);
    page_write(2'd0, 8'h5A);
    pulse_load(4'b0001);
    check("R2", "ch0 addr", addr_of(0), 32'h1234);
    check("R6", "ch0 count", cnt_of(0), 4);
    check("R6", "ch0 phys", phys_of(0), 32'h5A1234);
    check("R8", "load keeps enable", 32'(chan_en[0]), 0);
  endtask

  task automatic t_unmask;
    io_write(4'hA, 8'h00);
    check("R7", "ch0 enabled", 32'(chan_en[0]), 1);
    check("R12", "ch0 toggle pulse", 32'(en_toggle), 32'h1);
    @(negedge clk);
    check("R12", "toggle one cycle", 32'(en_toggle), 0);
  endtask

  task automatic t_single_run;
    for (int i = 0; i < 3; i++) pulse_step(4'b0001);
    check("R9", "ch0 addr after 3", addr_of(0), 32'h1237);
    check("R9", "ch0 count after 3", cnt_of(0), 1);
    check("R9", "ch0 still on", 32'(chan_en[0]), 1);
    pulse_step(4'b0001);
    check("R10", "ch0 count empty", cnt_of(0), 0);
    check("R10", "ch0 off", 32'(chan_en[0]), 0);
    check("R12", "ch0 off pulse", 32'(en_toggle), 32'h1);
    pulse_step(4'b0001);
    check("R9", "step ignored at zero", addr_of(0), 32'h1238);
  endtask

  task automatic t_reprog;
    io_write(4'hC, 8'h00);
    io_write(4'h0, 8'h00);
    io_write(4'h0, 8'h20);
    check("R8", "addr write no eval", 32'(chan_en[0]), 0);
    page_write(2'd0, 8'h11);
    check("R8", "page write no eval", 32'(chan_en[0]), 0);
    check("R8", "current addr untouched", addr_of(0), 32'h1238);
    io_write(4'hA, 8'h00);
    check("R7", "reprogrammed re-enables", 32'(chan_en[0]), 1);
    io_write(4'hA, 8'h04);
    check("R4", "mask disables", 32'(chan_en[0]), 0);
  endtask

  task automatic t_autoinit;
    io_write(4'h2, 8'h99);
    io_write(4'hC, 8'h00);
    io_write(4'h2, 8'h11);
    io_write(4'h2, 8'hAB);
    io_write(4'hC, 8'h00);
    io_write(4'h3, 8'h01);
    io_write(4'h3, 8'h00);
    pulse_load(4'b0010);
    check("R3", "ch1 addr after clear", addr_of(1), 32'hAB11);
    check("R6", "ch1 count", cnt_of(1), 2);
    pulse_step(4'b0010);
    check("R9", "masked step ignored", cnt_of(1), 2);
    io_write(4'hB, 8'h11);
    check("R5", "mode on masked ch1", 32'(chan_en[1]), 0);
    io_write(4'hA, 8'h01);
    check("R4", "ch1 unmasked", 32'(chan_en[1]), 1);
    pulse_step(4'b0010);
    check("R9", "ch1 count 1", cnt_of(1), 1);
    pulse_step(4'b0010);
    check("R11", "ch1 reload count", cnt_of(1), 2);
    check("R11", "ch1 reload addr", addr_of(1), 32'hAB11);
    check("R11", "ch1 stays on", 32'(chan_en[1]), 1);
    check("R11", "no toggle on reload", 32'(en_toggle), 0);
  endtask

  task automatic t_mode_switch;
    io_write(4'hB, 8'h01);
    check("R5", "single mode, count left", 32'(chan_en[1]), 1);
    pulse_step(4'b0010);
    pulse_step(4'b0010);
    check("R10", "ch1 empties", cnt_of(1), 0);
    check("R10", "ch1 off", 32'(chan_en[1]), 0);
  endtask

  task automatic t_illegal;
    io_write(4'h8, 8'h04);
    check("R13", "legal cmd", 32'(cmd_err), 0);
    io_write(4'h8, 8'h10);
    check("R13", "illegal cmd", 32'(cmd_err), 1);
    @(negedge clk);
    check("R13", "pulse ends", 32'(cmd_err), 0);
  endtask

  task automatic t_wrap;
    io_write(4'hC, 8'h00);
    io_write(4'h4, 8'hFF);
    io_write(4'h4, 8'hFF);
    io_write(4'h5, 8'h01);
    io_write(4'h5, 8'h00);
    page_write(2'd2, 8'h03);
    pulse_load(4'b0100);
    io_write(4'hA, 8'h02);
    pulse_step(4'b0100);
    check("R9", "ch2 addr wraps", addr_of(2), 32'h0000);
    check("R9", "ch2 phys no carry", phys_of(2), 32'h030000);
    check("R9", "ch2 count", cnt_of(2), 1);
  endtask

  task automatic t_shared_ptr;
    io_write(4'hA, 8'h03);
    check("R7", "ch3 zero count off", 32'(chan_en[3]), 0);
    check("R12", "no toggle", 32'(en_toggle), 0);
    io_write(4'hB, 8'h13);
    check("R7", "ch3 autoinit on", 32'(chan_en[3]), 1);
    io_write(4'hC, 8'h00);
    io_write(4'h6, 8'h77);
    io_write(4'h7, 8'h05);
    io_write(4'h7, 8'h00);
    pulse_load(4'b1000);
    check("R2", "shared pointer count", cnt_of(3), 32'h0501);
    check("R2", "ch3 addr", addr_of(3), 32'h0077);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_we = 0; io_ofs = 0; io_data = 0;
    page_we = 0; page_ch = 0; page_data = 0; xfer_load = 0; xfer_step = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program_load();
    t_unmask();
    t_single_run();
    t_reprog();
    t_autoinit();
    t_mode_switch();
    t_illegal();
    t_wrap();
    t_shared_ptr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule